// File: doc/BRIEF.md
# Credit-Gated Round-Robin DRAM Request Arbiter

This block sits between several sub-partition request queues and a single DRAM request port. Each cycle it looks at which queues hold a request and selects at most one to send to DRAM. The selected queue receives a pop strobe in the same cycle, and the DRAM port receives the grant. Admission is metered by credits. Every requester owns one guaranteed slot. Beyond that slot it competes for a shared pool, whose size follows from the depths of the downstream scheduler, return and write queues. A credit is taken when a request issues. It is handed back when the matching response lands in that requester's return queue, which the surrounding logic reports with a per-requester strobe.

Each private slot is a two-state machine. `SLOT_FREE` moves to `SLOT_HELD` when its requester borrows, and `SLOT_HELD` moves back to `SLOT_FREE` when a credit is returned. A borrow while the slot is held is charged to the shared counter instead. A return while the slot is free is refunded from the shared counter. The search pointer works as a second state register. It holds the most recent borrower and changes only when a request is issued.

Top module: `cra_dram_arbiter`

## Requirements
- R1: After reset every private slot is free, the shared count is zero and the pointer names requester N-1, so requester 0 is searched first.
- R2: A requester is eligible only when all three of these hold: its `req_valid` is 1, its `ret_full` is 0, and it has credit.
- R3: The search visits requesters in round-robin order, starting at the one after the last borrower. The pointer moves only when a request issues.
- R4: The first eligible requester in search order is chosen. If the DRAM full flag for that request's type is set (`dram_wr_full` when `req_is_wr` is 1, `dram_rd_full` otherwise), nothing issues that cycle and no later requester is tried.
- R5: At most one request issues per cycle. `req_pop` is one-hot at index `dram_issue_id` when `dram_issue` is 1, and zero otherwise. `dram_issue_wr` copies that requester's `req_is_wr`.
- R6: A requester has credit when its private slot is free, or when the shared count is below the shared limit. A borrow takes the private slot first and the shared pool second.
- R7: The shared limit is SCHED_DEPTH + RET_DEPTH - (N_REQ-1), plus WR_DEPTH when SEP_WR is 1. When every slot is held and the shared count has reached this limit, no request issues.
- R8: If SCHED_DEPTH or RET_DEPTH is 0, the shared pool has no limit, and a requester keeps issuing with no credit ever returned.
- R9: A return frees the requester's private slot when it is held, and otherwise decrements the shared count. When a return and a borrow by the same requester fall in one cycle, the return is applied first and the borrow is applied to the result.
- R10: `err_underflow` is 1 in any cycle where a return finds the slot free and the shared count at zero; the shared count then stays at zero. `err_overborrow` is 1 only for a borrow without credit, and never on legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request queue of each requester is non-empty |
| req_is_wr | input | N_REQ | Head request of each queue is a write |
| ret_full | input | N_REQ | Return queue of each requester is full |
| dram_rd_full | input | 1 | DRAM cannot take a read |
| dram_wr_full | input | 1 | DRAM cannot take a write |
| credit_ret | input | N_REQ | Per-requester credit return strobe |
| req_pop | output | N_REQ | Pop strobe to the granted queue |
| dram_issue | output | 1 | A request is sent to DRAM this cycle |
| dram_issue_id | output | IDW | Index of the issuing requester |
| dram_issue_wr | output | 1 | Issued request is a write |
| err_overborrow | output | 1 | Borrow attempted without credit |
| err_underflow | output | 1 | Return would drive the shared count negative |

## Verification
Directed cases come first. An idle cycle and an all-valid burst after reset confirm the starting pointer and the rotation. A blocked read at the head of the search, with an eligible write behind it, shows the difference between abandoning the cycle and skipping ahead. A full drain of private and shared credits finds the exact exhaustion point. Returns then refill the credits, and a surplus return raises the underflow flag. After that, constrained random valid, type, return-full, DRAM-full and return patterns run against a bench model of the slots, the shared count and the pointer. A second instance with an unlimited pool shows that the limit is not applied there.

// File: rtl/cra_pkg.sv
package cra_pkg;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    function automatic int calc_shared_limit(input int sched_d, input int ret_d,
                                             input int wr_d, input int sep_wr,
                                             input int n_req);
        int lim;
        lim = sched_d + ret_d - (n_req - 1);
        if (sep_wr != 0) lim = lim + wr_d;
        if (sched_d == 0 || ret_d == 0) lim = 0;
        if (lim < 0) lim = 0;
        return lim;
    endfunction

endpackage

// File: rtl/cra_credit_ledger.sv
module cra_credit_ledger
    import cra_pkg::*;
#(
    parameter int N_REQ     = 4,
    parameter int SH_W      = 8,
    parameter int SH_LIMIT  = 29,
    parameter bit UNLIMITED = 1'b0,
    localparam int IDW      = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             borrow_vld,
    input  logic [IDW-1:0]   borrow_id,
    input  logic [N_REQ-1:0] ret_strobe,
    output logic [N_REQ-1:0] has_credit,
    output logic             err_overborrow,
    output logic             err_underflow
);

    localparam logic [SH_W-1:0] LIM_V = SH_W'(SH_LIMIT);
    localparam logic [SH_W-1:0] SAT_V = {SH_W{1'b1}};

    slot_state_e     slot_q [N_REQ];
    slot_state_e     slot_d [N_REQ];
    logic [SH_W-1:0] shared_q;
    logic [SH_W-1:0] shared_d;
    logic            pool_open;

    assign pool_open = UNLIMITED || (shared_q < LIM_V);

    generate
        for (genvar g = 0; g < N_REQ; g++) begin : g_credit
            assign has_credit[g] = (slot_q[g] == SLOT_FREE) || pool_open;
        end
    endgenerate

    // Returns first, against the registered state; the borrow then sees the result.
    always_comb begin
        shared_d       = shared_q;
        err_underflow  = 1'b0;
        err_overborrow = 1'b0;
        for (int i = 0; i < N_REQ; i++) slot_d[i] = slot_q[i];
        for (int i = 0; i < N_REQ; i++) begin
            if (ret_strobe[i]) begin
                unique case (slot_q[i])
                    SLOT_HELD: slot_d[i] = SLOT_FREE;
                    SLOT_FREE: begin
                        if (shared_d != '0) shared_d = shared_d - 1'b1;
                        else                err_underflow = 1'b1;
                    end
                endcase
            end
        end
        if (borrow_vld) begin
            unique case (slot_d[borrow_id])
                SLOT_FREE: slot_d[borrow_id] = SLOT_HELD;
                SLOT_HELD: begin
                    if (UNLIMITED) begin
                        if (shared_d != SAT_V) shared_d = shared_d + 1'b1;
                    end else if (shared_d < LIM_V) begin
                        shared_d = shared_d + 1'b1;
                    end else begin
                        err_overborrow = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shared_q <= '0;
            for (int i = 0; i < N_REQ; i++) slot_q[i] <= SLOT_FREE;
        end else begin
            shared_q <= shared_d;
            for (int i = 0; i < N_REQ; i++) slot_q[i] <= slot_d[i];
        end
    end

endmodule

// File: rtl/cra_rr_pick.sv
module cra_rr_pick #(
    parameter int N_REQ = 4,
    localparam int IDW  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] eligible,
    input  logic [N_REQ-1:0] req_is_wr,
    input  logic [IDW-1:0]   last_id,
    input  logic             dram_rd_full,
    input  logic             dram_wr_full,
    output logic             grant_vld,
    output logic [IDW-1:0]   grant_id
);

    logic found;
    logic blocked;

    always_comb begin
        found    = 1'b0;
        grant_id = '0;
        for (int k = 0; k < N_REQ; k++) begin
            int idx;
            idx = int'(last_id) + 1 + k;
            if (idx >= N_REQ) idx = idx - N_REQ;
            if (!found && eligible[idx]) begin
                found    = 1'b1;
                grant_id = IDW'(idx);
            end
        end
        blocked   = found && (req_is_wr[grant_id] ? dram_wr_full : dram_rd_full);
        grant_vld = found && !blocked;
    end

endmodule

// File: rtl/cra_dram_arbiter.sv
module cra_dram_arbiter
    import cra_pkg::*;
#(
    parameter int N_REQ       = 4,
    parameter int SCHED_DEPTH = 16,
    parameter int RET_DEPTH   = 8,
    parameter int WR_DEPTH    = 8,
    parameter bit SEP_WR      = 1'b1,
    parameter int SH_W        = 8,
    localparam int IDW        = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_valid,
    input  logic [N_REQ-1:0] req_is_wr,
    input  logic [N_REQ-1:0] ret_full,
    input  logic             dram_rd_full,
    input  logic             dram_wr_full,
    input  logic [N_REQ-1:0] credit_ret,
    output logic [N_REQ-1:0] req_pop,
    output logic             dram_issue,
    output logic [IDW-1:0]   dram_issue_id,
    output logic             dram_issue_wr,
    output logic             err_overborrow,
    output logic             err_underflow
);

    localparam int SH_LIMIT  = calc_shared_limit(SCHED_DEPTH, RET_DEPTH, WR_DEPTH,
                                                 int'(SEP_WR), N_REQ);
    localparam bit UNLIMITED = (SH_LIMIT == 0);
    localparam logic [IDW-1:0] LAST_RST = IDW'(N_REQ - 1);

    logic [N_REQ-1:0] has_credit;
    logic [N_REQ-1:0] eligible;
    logic [IDW-1:0]   last_q;
    logic             grant_vld;
    logic [IDW-1:0]   grant_id;

    assign eligible = req_valid & has_credit & ~ret_full;

    cra_credit_ledger #(
        .N_REQ     (N_REQ),
        .SH_W      (SH_W),
        .SH_LIMIT  (SH_LIMIT),
        .UNLIMITED (UNLIMITED)
    ) u_ledger (
        .clk            (clk),
        .rst_n          (rst_n),
        .borrow_vld     (grant_vld),
        .borrow_id      (grant_id),
        .ret_strobe     (credit_ret),
        .has_credit     (has_credit),
        .err_overborrow (err_overborrow),
        .err_underflow  (err_underflow)
    );

    cra_rr_pick #(.N_REQ(N_REQ)) u_pick (
        .eligible     (eligible),
        .req_is_wr    (req_is_wr),
        .last_id      (last_q),
        .dram_rd_full (dram_rd_full),
        .dram_wr_full (dram_wr_full),
        .grant_vld    (grant_vld),
        .grant_id     (grant_id)
    );

    // Pointer register: moves only on an issue.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= LAST_RST;
        else if (grant_vld) last_q <= grant_id;
    end

    // Output decode.
    always_comb begin
        req_pop       = '0;
        dram_issue    = grant_vld;
        dram_issue_id = grant_id;
        dram_issue_wr = grant_vld && req_is_wr[grant_id];
        if (grant_vld) req_pop[grant_id] = 1'b1;
    end

endmodule

// File: rtl/cra_dram_arbiter_chk.sv
module cra_dram_arbiter_chk #(
    parameter int N_REQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req_valid,
    input logic [N_REQ-1:0] ret_full,
    input logic [N_REQ-1:0] req_pop,
    input logic             dram_issue,
    input logic             dram_issue_wr,
    input logic             dram_rd_full,
    input logic             dram_wr_full,
    input logic             err_overborrow
);

    AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_pop));                                               // R5

    AST_POP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dram_issue == ($countones(req_pop) == 1));                         // R5

    AST_POP_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pop & (~req_valid | ret_full)) == '0);                       // R2

    AST_WR_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_issue && dram_issue_wr) |-> !dram_wr_full);                  // R4

    AST_RD_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_issue && !dram_issue_wr) |-> !dram_rd_full);                 // R4

    AST_NO_OVERBORROW: assert property (@(posedge clk) disable iff (!rst_n)
        !err_overborrow);                                                  // R10

endmodule

bind cra_dram_arbiter cra_dram_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .ret_full       (ret_full),
    .req_pop        (req_pop),
    .dram_issue     (dram_issue),
    .dram_issue_wr  (dram_issue_wr),
    .dram_rd_full   (dram_rd_full),
    .dram_wr_full   (dram_wr_full),
    .err_overborrow (err_overborrow)
);

// File: tb/test_cra_dram_arbiter.sv
`timescale 1ns/1ps
module test_cra_dram_arbiter;

    localparam int N   = 4;
    localparam int IDW = 2;
    localparam int LIM = 2;   // 2 + 2 - 3 + 1

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]   req_valid = '0, req_is_wr = '0, ret_full = '0, credit_ret = '0;
    logic           dram_rd_full = 1'b0, dram_wr_full = 1'b0;
    logic [N-1:0]   req_pop;
    logic           dram_issue, dram_issue_wr, err_overborrow, err_underflow;
    logic [IDW-1:0] dram_issue_id;

    logic [N-1:0]   u_valid = '0;
    logic [N-1:0]   u_pop;
    logic           u_issue, u_issue_wr, u_over, u_under;
    logic [IDW-1:0] u_id;

    cra_dram_arbiter #(.N_REQ(N), .SCHED_DEPTH(2), .RET_DEPTH(2), .WR_DEPTH(1),
                       .SEP_WR(1'b1), .SH_W(4)) i_cra_dram_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_wr(req_is_wr),
        .ret_full(ret_full), .dram_rd_full(dram_rd_full), .dram_wr_full(dram_wr_full),
        .credit_ret(credit_ret), .req_pop(req_pop), .dram_issue(dram_issue),
        .dram_issue_id(dram_issue_id), .dram_issue_wr(dram_issue_wr),
        .err_overborrow(err_overborrow), .err_underflow(err_underflow));

    cra_dram_arbiter #(.N_REQ(N), .SCHED_DEPTH(0), .RET_DEPTH(2), .WR_DEPTH(1),
                       .SEP_WR(1'b1), .SH_W(4)) i_cra_dram_arbiter_unl (
        .clk(clk), .rst_n(rst_n), .req_valid(u_valid), .req_is_wr('0),
        .ret_full('0), .dram_rd_full(1'b0), .dram_wr_full(1'b0),
        .credit_ret('0), .req_pop(u_pop), .dram_issue(u_issue),
        .dram_issue_id(u_id), .dram_issue_wr(u_issue_wr),
        .err_overborrow(u_over), .err_underflow(u_under));

    int n_vec = 0, n_bad = 0;
    bit m_priv [N];
    int m_sh, m_last;
    int m_out [N];

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit credit_ok(input int i);
        return !m_priv[i] || (m_sh < LIM);
    endfunction

    // Drive one cycle, compare against the model, then advance the model.
    task automatic apply(input string tag, input logic [N-1:0] v, input logic [N-1:0] w,
                         input logic [N-1:0] rf, input logic rdf, input logic wrf,
                         input logic [N-1:0] rt);
        int  e_id;
        bit  found, e_issue, e_under;
        bit  t_priv [N];
        int  t_sh;
        @(negedge clk);
        req_valid = v; req_is_wr = w; ret_full = rf;
        dram_rd_full = rdf; dram_wr_full = wrf; credit_ret = rt;
        #1;
        found = 0; e_id = 0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (m_last + 1 + k) % N;
            if (!found && v[idx] && !rf[idx] && credit_ok(idx)) begin
                found = 1; e_id = idx;
            end
        end
        e_issue = found && !(w[e_id] ? wrf : rdf);
        e_under = 0;
        for (int i = 0; i < N; i++) t_priv[i] = m_priv[i];
        t_sh = m_sh;
        for (int i = 0; i < N; i++) begin
            if (rt[i]) begin
                if (t_priv[i]) t_priv[i] = 0;
                else if (t_sh > 0) t_sh--;
                else e_under = 1;
                if (m_out[i] > 0) m_out[i]--;
            end
        end
        if (e_issue) begin
            if (!t_priv[e_id]) t_priv[e_id] = 1;
            else t_sh++;
            m_out[e_id]++;
        end
        check({tag, " R5 issue"}, int'(dram_issue), int'(e_issue));
        check({tag, " R5 pop"}, int'(req_pop), e_issue ? (1 << e_id) : 0);
        if (e_issue) begin
            check({tag, " R3 id"}, int'(dram_issue_id), e_id);
            check({tag, " R5 wr"}, int'(dram_issue_wr), int'(w[e_id]));
        end
        check({tag, " R10 underflow"}, int'(err_underflow), int'(e_under));
        check({tag, " R10 overborrow"}, int'(err_overborrow), 0);
        @(posedge clk);
        for (int i = 0; i < N; i++) m_priv[i] = t_priv[i];
        m_sh = t_sh;
        if (e_issue) m_last = e_id;
    endtask

    initial begin
        void'($urandom(32'd5129));
        for (int i = 0; i < N; i++) begin m_priv[i] = 0; m_out[i] = 0; end
        m_sh = 0; m_last = N - 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: idle after reset
        apply("R1 idle", '0, '0, '0, 0, 0, '0);
        // R4: requester 1 read blocked by dram_rd_full; write at 2 must not be tried
        apply("R4 blocked head", 4'b0110, 4'b0100, '0, 1, 0, '0);
        check("R4 nothing issued", int'(dram_issue), 0);
        // R1: pointer still at N-1, requester 0 goes first
        apply("R1 first", 4'b1111, '0, '0, 0, 0, '0);
        check("R1 requester 0 first", int'(m_last), 0);
        // R3: rotation through the rest
        apply("R3 rot1", 4'b1111, 4'b1010, '0, 0, 0, '0);
        apply("R3 rot2", 4'b1111, 4'b1010, '0, 0, 0, '0);
        apply("R3 rot3", 4'b1111, 4'b1010, '0, 0, 0, '0);
        // R2: return queue full excludes requester 0
        apply("R2 ret_full", 4'b0011, '0, 4'b0001, 0, 0, '0);
        check("R2 skip full requester", int'(m_last), 1);
        // R6/R7: second shared credit, then exhaustion
        apply("R6 shared", 4'b1111, '0, '0, 0, 0, '0);
        apply("R7 exhausted", 4'b1111, '0, '0, 0, 0, '0);
        check("R7 no issue when pool full", int'(m_sh), LIM);
        // R9: simultaneous return and borrow by requester 3
        apply("R9 ret+borrow", 4'b1000, '0, '0, 0, 0, 4'b1000);
        // R9: drain all outstanding credits one at a time
        for (int i = 0; i < N; i++)
            while (m_out[i] > 0) apply("R9 drain", '0, '0, '0, 0, 0, 4'(1 << i));
        // R10: surplus return
        apply("R10 surplus", '0, '0, '0, 0, 0, 4'b0100);

        // constrained random
        for (int c = 0; c < 400; c++) begin
            logic [N-1:0] rt;
            rt = '0;
            for (int i = 0; i < N; i++)
                if (m_out[i] > 0 && ($urandom % 3 == 0)) rt[i] = 1'b1;
            apply("R2/R3/R6/R9 rand", 4'($urandom), 4'($urandom),
                  4'(($urandom % 4 == 0) ? $urandom : 0),
                  1'($urandom % 5 == 0), 1'($urandom % 5 == 0), rt);
        end

        // R8: unlimited pool keeps issuing to one requester without returns
        @(negedge clk); u_valid = 4'b0001;
        for (int c = 0; c < 10; c++) begin
            #1;
            check("R8 unlimited issue", int'(u_pop), 1);
            @(negedge clk);
        end
        u_valid = '0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule